// File: doc/BRIEF.md
# Wait-State Request Controller

This block sits on the processor side of a small 8-bit system whose memory map is split in two. Accesses to the lower half of the address space go to fast RAM and run at full speed. Accesses with the top address bit set go to slow ROM or peripheral hardware. That slow side runs from its own clock and may take any number of processor cycles to respond.

On each rising edge of the processor clock, the controller checks the address. If the address is slow, it raises a wait request, and it holds the processor's ready input low until the slow side acknowledges. The acknowledge is active low and level sensitive. It arrives asynchronously and is sampled on the processor clock's rising edge. The slow side must keep it high whenever no request is outstanding.

The controller also produces three further outputs: the RAM select, a forwarded copy of the read/write strobe, and the enable for the buffered external data-bus transceiver. The transceiver enable drops during the low clock phase, which leaves a dead-time cushion at every bus handoff. The one exception is a stalled write: the enable stays on through the low phase so that slow devices keep seeing stable write data.

Top module: `slow_wait_ctrl`

## Requirements
- R1: An address below the slow-region base (top address bit 0) drives ramSel high and never raises waitReq.
- R2: With waitReq low, a rising clock edge that samples an address with the top bit 1 sets waitReq to 1.
- R3: cpuRdy is 1 exactly when waitReq is 0.
- R4: With waitReq high, a rising edge that samples ackN at 0 clears waitReq at that edge. The clear wins even if the address is still slow.
- R5: With waitReq high, every rising edge that samples ackN at 1 keeps waitReq at 1, for any number of cycles.
- R6: ackN at 0 while waitReq is 0 has no effect: a RAM address leaves waitReq at 0.
- R7: xcvrEn is 1 during the high clock phase of a slow access and is 0 during the low clock phase, unless R8 applies.
- R8: While waitReq is 1 and cpuRwb is 0 (a stalled write), xcvrEn stays 1 through the low clock phase.
- R9: extRwb always equals cpuRwb (1 = read, 0 = write).
- R10: rstN low (asynchronous) clears waitReq and drives cpuRdy to 1.
- R11: A slow access that follows a cleared one sets waitReq again on the very next rising edge, even while ackN is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; the high level is the data phase |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | ADDR_W | Processor address |
| cpuRwb | input | 1 | Processor read/write strobe, 1 = read |
| ackN | input | 1 | Active-low, level-sensitive slow-side acknowledge |
| waitReq | output | 1 | Outstanding slow-access request, sent to the slow side |
| cpuRdy | output | 1 | Processor ready input, low while stalled |
| ramSel | output | 1 | Fast RAM select, high for the lower region |
| xcvrEn | output | 1 | External data-bus transceiver enable |
| extRwb | output | 1 | Buffered read/write strobe for the slow side |

## Verification
On every clock edge, the assertions check how the request flag moves: it sets on a slow address, holds while the acknowledge is high, clears on a low acknowledge, and never sets for RAM. They also check that a stalled write keeps the transceiver enabled. The bench's phase-by-phase sampling is what shows the release of the transceiver enable in the low clock phase, the forwarded strobe, reset taking effect in mid-stall, and re-arming on the edge right after a clear. A long pseudo-random sweep over address, strobe and acknowledge is compared against an arithmetic model of the flag.

// File: rtl/slow_wait_pkg.sv
package slow_wait_pkg;

  // Strobes passed from the control decode to the request datapath.
  typedef struct packed {
    logic setReq;   // start a new slow-access request this edge
    logic clrReq;   // acknowledge seen, retire the request this edge
    logic slowSel;  // current address lies in the slow region
  } waitStrobes_t;

endpackage

// File: rtl/slow_wait_ctl.sv
module slow_wait_ctl
  import slow_wait_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              ackN,
  input  logic              waitReq,
  output waitStrobes_t      strobes
);

  // First address of the slow region: everything with the top bit set.
  localparam logic [ADDR_W-1:0] SLOW_BASE = ADDR_W'(1) << (ADDR_W - 1);

  logic ackSeenN;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      // Acknowledge sampled straight at the request edge.
      assign ackSeenN = ackN;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chain <= '1;
        end else begin
          chain[0] <= ackN;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            chain[i] <= chain[i-1];
          end
        end
      end
      assign ackSeenN = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    strobes.slowSel = (cpuAddr >= SLOW_BASE);
    // Retiring has priority: no new request on the edge that clears one.
    strobes.clrReq  = waitReq & ~ackSeenN;
    strobes.setReq  = ~waitReq & strobes.slowSel;
  end

endmodule

// File: rtl/slow_wait_dp.sv
module slow_wait_dp
  import slow_wait_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuRwb,
  input  waitStrobes_t strobes,
  output logic         waitReq,
  output logic         cpuRdy,
  output logic         ramSel,
  output logic         xcvrEn,
  output logic         extRwb
);

  logic reqQ;
  logic stalledWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
    end else if (strobes.clrReq) begin
      reqQ <= 1'b0;
    end else if (strobes.setReq) begin
      reqQ <= 1'b1;
    end
  end

  assign stalledWrite = reqQ & ~cpuRwb;

  assign waitReq = reqQ;
  assign cpuRdy  = ~reqQ;
  assign ramSel  = ~strobes.slowSel;
  // Drive the external bus only in the high phase, except a stalled write.
  assign xcvrEn  = (clk & strobes.slowSel) | stalledWrite;
  assign extRwb  = cpuRwb;

endmodule

// File: rtl/slow_wait_ctrl.sv
module slow_wait_ctrl
  import slow_wait_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRwb,
  input  logic              ackN,
  output logic              waitReq,
  output logic              cpuRdy,
  output logic              ramSel,
  output logic              xcvrEn,
  output logic              extRwb
);

  waitStrobes_t strobes;

  slow_wait_ctl #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .cpuAddr(cpuAddr),
    .ackN   (ackN),
    .waitReq(waitReq),
    .strobes(strobes)
  );

  slow_wait_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cpuRwb (cpuRwb),
    .strobes(strobes),
    .waitReq(waitReq),
    .cpuRdy (cpuRdy),
    .ramSel (ramSel),
    .xcvrEn (xcvrEn),
    .extRwb (extRwb)
  );

endmodule

// File: rtl/slow_wait_chk.sv
module slow_wait_chk #(
  parameter int SYNC_STAGES = 0
) (
  input logic clk,
  input logic rstN,
  input logic slowBit,
  input logic cpuRwb,
  input logic ackN,
  input logic waitReq,
  input logic cpuRdy,
  input logic ramSel,
  input logic xcvrEn
);

  // R2: a slow address with no pending request starts one and stalls the CPU
  p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!waitReq && slowBit) |=> (waitReq && !cpuRdy));

  // R1: a RAM access never raises a request
  p_ram_nowait_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ramSel && !waitReq) |=> !waitReq);

  // R6: acknowledge low without a request has no effect on a RAM access
  p_ack_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!waitReq && !ackN && !slowBit) |=> (!waitReq && cpuRdy));

  // R11: a request can be raised again on the edge right after a clear
  p_rearm_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(waitReq) && slowBit) |=> waitReq);

  // R8: a stalled write keeps the external bus driven
  p_wr_drive_r8: assert property (@(negedge clk) disable iff (!rstN)
    (waitReq && !cpuRwb) |-> xcvrEn);

  generate
    if (SYNC_STAGES == 0) begin : g_direct_ack
      // R4: acknowledge low retires the request on the same edge
      p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
        (waitReq && !ackN) |=> (!waitReq && cpuRdy));

      // R5: acknowledge high holds the stall
      p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
        (waitReq && ackN) |=> (waitReq && !cpuRdy));
    end
  endgenerate

endmodule

bind slow_wait_ctrl slow_wait_chk #(
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .slowBit(cpuAddr[ADDR_W-1]),
  .cpuRwb (cpuRwb),
  .ackN   (ackN),
  .waitReq(waitReq),
  .cpuRdy (cpuRdy),
  .ramSel (ramSel),
  .xcvrEn (xcvrEn)
);

// File: tb/sim_slow_wait_ctrl.sv
`timescale 1ns/1ps
module sim_slow_wait_ctrl;

  localparam int AW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN;
  logic [AW-1:0] cpuAddr;
  logic          cpuRwb;
  logic          ackN;
  logic          waitReq, cpuRdy, ramSel, xcvrEn, extRwb;

  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;
  logic mFlag;

  slow_wait_ctrl #(.ADDR_W(AW), .SYNC_STAGES(0)) u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRwb(cpuRwb), .ackN(ackN),
    .waitReq(waitReq), .cpuRdy(cpuRdy), .ramSel(ramSel), .xcvrEn(xcvrEn),
    .extRwb(extRwb)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Called at negedge+1: drive, cross one rising edge, check both phases.
  task automatic step(input logic [AW-1:0] a, input logic rw, input logic ak);
    logic  top, prev;
    string t;
    cpuAddr = a; cpuRwb = rw; ackN = ak; top = a[AW-1];
    @(posedge clk);
    prev = mFlag;
    if (mFlag && !ak)       mFlag = 1'b0;
    else if (!mFlag && top) mFlag = 1'b1;
    if (prev && !mFlag)      t = "R4";
    else if (!prev && mFlag) t = "R2";
    else if (prev)           t = "R5";
    else if (!ak)            t = "R6";
    else                     t = "R1";
    #1;
    chk(t,    "waitReq",      waitReq, mFlag);
    chk("R3", "cpuRdy",       cpuRdy,  !mFlag);
    chk("R1", "ramSel",       ramSel,  !top);
    chk("R9", "extRwb",       extRwb,  rw);
    chk("R7", "xcvrEn high",  xcvrEn,  top | (mFlag & !rw));
    @(negedge clk);
    #1;
    chk((mFlag && !rw) ? "R8" : "R7", "xcvrEn low", xcvrEn, mFlag & !rw);
  endtask

  initial begin
    logic [15:0] lfsr;
    rstN = 1'b0; cpuAddr = 16'h8000; cpuRwb = 1'b1; ackN = 1'b1; mFlag = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "waitReq in reset", waitReq, 1'b0);
    chk("R10", "cpuRdy in reset",  cpuRdy,  1'b1);
    @(negedge clk); #1;
    rstN = 1'b1;

    // R1: RAM read and write, no stall
    step(16'h1234, 1'b1, 1'b1);
    step(16'h7FFF, 1'b0, 1'b1);
    // R2/R5/R4: slow read, two held cycles, then acknowledge
    step(16'h8000, 1'b1, 1'b1);
    step(16'h8000, 1'b1, 1'b1);
    step(16'h8000, 1'b1, 1'b1);
    step(16'h8000, 1'b1, 1'b0);
    // R6: stale acknowledge with a RAM access
    step(16'h0010, 1'b1, 1'b0);
    // R8: stalled write keeps the bus driven in the low phase
    step(16'h9000, 1'b0, 1'b1);
    step(16'h9000, 1'b0, 1'b1);
    step(16'h9000, 1'b0, 1'b0);
    // R11: back-to-back slow access re-arms despite acknowledge still low
    step(16'hA000, 1'b1, 1'b1);
    step(16'hA000, 1'b1, 1'b0);
    step(16'hC000, 1'b1, 1'b0);
    chk("R11", "waitReq back-to-back", waitReq, 1'b1);
    step(16'hC000, 1'b1, 1'b0);

    // R10: reset in the middle of a stall
    step(16'hFFFF, 1'b1, 1'b1);
    rstN = 1'b0;
    #1;
    chk("R10", "waitReq after mid reset", waitReq, 1'b0);
    chk("R10", "cpuRdy after mid reset",  cpuRdy,  1'b1);
    mFlag = 1'b0;
    @(negedge clk); #1;
    rstN = 1'b1;

    // Sweep over address region, strobe and acknowledge patterns
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      step(lfsr, lfsr[3], !(lfsr[5] & lfsr[7]));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule